// File: doc/BRIEF.md
# Interruptible Window Prefetch Controller

This controller sits between one client port and a word-wide memory read path. When the client finishes a read transaction, it predicts that the next transaction will start right after the window it just served. It then uses the idle time, while the client works on its data, to read that predicted window into a small on-chip buffer. The size of the window is the parameter `WIN`.

A client request can arrive while the prefetch is still running. The controller then freezes the prefetch and keeps its word count and next address. In a separate cycle it compares the request with the predicted window.

- **Match:** the frozen prefetch picks up where it stopped. The client receives the buffered words, one per cycle, and the rest as they arrive from memory.
- **Mismatch:** the buffer is discarded, and the request is served straight from memory.

Two event counters record matches and mismatches.

The client request and response and the memory request and response use valid/ready handshakes, with the exceptions noted here:

- A response word is transferred on a cycle where `rsp_valid` and `rsp_ready` are both high. While `rsp_ready` is low, the word stays put.
- A memory request that has been raised stays raised, with its address, until `mem_req_ready`.
- Memory returns exactly one `mem_rsp_valid` pulse for each accepted request, in order, and it cannot be stalled.

Top module: `wpf_prefetch_ctrl`

## Requirements
- R1: While and right after reset: `req_ready` is 1, `rsp_valid` is 0, `mem_req_valid` is 0, `hit_count` is 0 and `miss_count` is 0. No prediction exists.
- R2: A request with no prediction in place is read from memory. It returns `req_len` words, and word i is the memory content at `req_addr + i`, in order.
- R3: After each completed transaction, the idle period reads addresses `start + WIN` through `start + 2*WIN - 1`, once each and in rising order, where start is that transaction's address. After that window, no further memory request is made while idle.
- R4: A request arrives after the whole predicted window has been fetched, with the same start address and `req_len <= WIN`. It adds one to `hit_count` and is served with no memory read while it is open.
- R5: A matching request that arrives while the window is only partly fetched resumes the saved prefetch, adds one to `hit_count` and returns correct data for every word.
- R6: A request with a different start address, or with `req_len > WIN`, adds one to `miss_count`. It is served from memory with correct data, and no discarded prefetch word is ever returned.
- R7: The counters change only when a request is compared with a prediction. In any cycle at most one of them changes, and only by one. A request with no prediction changes neither.
- R8: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_data` hold. No word is lost or repeated.
- R9: Once `mem_req_valid` is high without `mem_req_ready`, `mem_req_valid` and `mem_req_addr` hold on the next cycle.
- R10: `req_ready` is low from acceptance until the last response word is taken. It is never high together with `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Client request valid |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | AW | Word address of the first word |
| req_len | input | LW | Word count, 1 to MAX_LEN |
| rsp_valid | output | 1 | Response word valid |
| rsp_ready | input | 1 | Client takes the response word |
| rsp_data | output | DW | Response word |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | AW | Memory read word address |
| mem_rsp_valid | input | 1 | Read data valid, one per accepted request, in order |
| mem_rsp_data | input | DW | Read data |
| hit_count | output | CW | Number of matched predictions, wraps |
| miss_count | output | CW | Number of mismatched predictions, wraps |

## Verification
The bench builds the block with `WIN = 4`, `MAX_LEN = 8`, 16-bit addresses and data, and 8-bit counters. It drives it from a memory model with a three-cycle round trip and a periodic request stall.

With a maximum length of twice the window, the bench can issue a request at the predicted address that still mismatches because it is too long. With a short window, the bench can do the following within a few cycles of a transaction ending:

- complete a prefetch;
- interrupt a prefetch half way;
- catch a prefetch read in flight.

Using zero, small and long idle gaps, the bench exercises the fully fetched hit, the resumed hit and the mismatch that must drop a word already in flight.

// File: rtl/wpf_pkg.sv
package wpf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEMAND,
    ST_PREFETCH,
    ST_HALT_CMP,
    ST_RESUME
  } wpf_state_e;
endpackage

// File: rtl/wpf_window_buf.sv
// Window-sized holding store: one data slot and one valid flag per word.
module wpf_window_buf #(
  parameter int WIN = 4,
  parameter int DW  = 16,
  parameter int IW  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  logic [WIN-1:0] slot_vld;
  logic [DW-1:0]  slot_dat [WIN];

  for (genvar g = 0; g < WIN; g++) begin : g_slot
    logic          v_q;
    logic [DW-1:0] d_q;
    logic          hit;
    assign hit = wr_en && (wr_idx == IW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   v_q <= 1'b0;
      else if (clr) v_q <= 1'b0;
      else if (hit) v_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (hit && !clr) d_q <= wr_data;
    end

    assign slot_vld[g] = v_q;
    assign slot_dat[g] = d_q;
  end

  assign rd_valid = slot_vld[rd_idx];
  assign rd_data  = slot_dat[rd_idx];
endmodule

// File: rtl/wpf_evt_cnt.sv
// Wrapping event counter.
module wpf_evt_cnt #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (inc) count <= count + CW'(1);
  end
endmodule

// File: rtl/wpf_prefetch_ctrl.sv
module wpf_prefetch_ctrl
  import wpf_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 16,
  parameter int WIN     = 4,
  parameter int MAX_LEN = 8,
  parameter int CW      = 8,
  localparam int LW     = $clog2(MAX_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [LW-1:0] req_len,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  output logic [CW-1:0] hit_count,
  output logic [CW-1:0] miss_count
);
  localparam int PW = $clog2(WIN + 1);
  localparam int IW = (WIN > 1) ? $clog2(WIN) : 1;

  wpf_state_e    st_q;
  logic [AW-1:0] cur_addr_q, pf_base_q, mreq_a_q;
  logic [LW-1:0] cur_len_q, ld_cnt_q, dm_cnt_q;
  logic [PW-1:0] pf_cnt_q;
  logic [IW-1:0] pf_idx_q;
  logic          pf_valid_q, busy_q, own_pf_q, drop_q, mreq_v_q;
  logic          rsp_v_q, rsp_last_q;
  logic [DW-1:0] rsp_d_q;
  logic          buf_rd_valid;
  logic [DW-1:0] buf_rd_data;

  // handshakes and events
  logic req_fire, rsp_fire, rsp_free, mrsp_take, pf_wr, dm_ld, buf_ld;
  logic match, txn_done, hit_ev, miss_ev, buf_clr, pf_issue, dm_issue;
  logic pf_more;

  assign req_ready = (st_q == ST_IDLE) || (st_q == ST_PREFETCH);
  assign req_fire  = req_valid && req_ready;
  assign rsp_fire  = rsp_v_q && rsp_ready;
  assign rsp_free  = !rsp_v_q || rsp_fire;
  assign mrsp_take = mem_rsp_valid && busy_q && !mreq_v_q;
  assign pf_wr     = mrsp_take && own_pf_q && !drop_q;
  assign dm_ld     = mrsp_take && !own_pf_q && !drop_q;

  assign match    = (cur_addr_q == pf_base_q) && (cur_len_q <= LW'(WIN));
  assign hit_ev   = (st_q == ST_HALT_CMP) && match;
  assign miss_ev  = (st_q == ST_HALT_CMP) && !match;
  assign txn_done = rsp_fire && rsp_last_q &&
                    ((st_q == ST_DEMAND) || (st_q == ST_RESUME));
  assign buf_clr  = miss_ev || txn_done;

  assign pf_more  = ({{LW{1'b0}}, pf_cnt_q} < {{PW{1'b0}}, cur_len_q});
  assign pf_issue = !busy_q && (
                     ((st_q == ST_PREFETCH) && !req_fire && (pf_cnt_q < PW'(WIN))) ||
                     ((st_q == ST_RESUME) && !txn_done && pf_more));
  assign dm_issue = !busy_q && (st_q == ST_DEMAND) && !rsp_v_q && (dm_cnt_q < cur_len_q);
  assign buf_ld   = (st_q == ST_RESUME) && buf_rd_valid && (ld_cnt_q < cur_len_q) && rsp_free;

  wpf_window_buf #(.WIN(WIN), .DW(DW), .IW(IW)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (buf_clr),
    .wr_en    (pf_wr),
    .wr_idx   (pf_idx_q),
    .wr_data  (mem_rsp_data),
    .rd_idx   (IW'(ld_cnt_q)),
    .rd_valid (buf_rd_valid),
    .rd_data  (buf_rd_data)
  );

  wpf_evt_cnt #(.CW(CW)) u_hit_cnt  (.clk(clk), .rst_n(rst_n), .inc(hit_ev),  .count(hit_count));
  wpf_evt_cnt #(.CW(CW)) u_miss_cnt (.clk(clk), .rst_n(rst_n), .inc(miss_ev), .count(miss_count));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      cur_addr_q <= '0;
      cur_len_q  <= '0;
      pf_base_q  <= '0;
      mreq_a_q   <= '0;
      ld_cnt_q   <= '0;
      dm_cnt_q   <= '0;
      pf_cnt_q   <= '0;
      pf_idx_q   <= '0;
      pf_valid_q <= 1'b0;
      busy_q     <= 1'b0;
      own_pf_q   <= 1'b0;
      drop_q     <= 1'b0;
      mreq_v_q   <= 1'b0;
      rsp_v_q    <= 1'b0;
      rsp_last_q <= 1'b0;
      rsp_d_q    <= '0;
    end else begin
      // memory side: one read in flight at most
      if (mreq_v_q && mem_req_ready) mreq_v_q <= 1'b0;
      if (pf_issue) begin
        mreq_v_q <= 1'b1;
        mreq_a_q <= pf_base_q + AW'(pf_cnt_q);
        busy_q   <= 1'b1;
        own_pf_q <= 1'b1;
        pf_idx_q <= IW'(pf_cnt_q);
        pf_cnt_q <= pf_cnt_q + PW'(1);
      end else if (dm_issue) begin
        mreq_v_q <= 1'b1;
        mreq_a_q <= cur_addr_q + AW'(dm_cnt_q);
        busy_q   <= 1'b1;
        own_pf_q <= 1'b0;
        dm_cnt_q <= dm_cnt_q + LW'(1);
      end
      if (mrsp_take) begin
        busy_q <= 1'b0;
        drop_q <= 1'b0;
      end else if (buf_clr && busy_q) begin
        drop_q <= 1'b1;
      end

      // client response register
      if (rsp_fire) rsp_v_q <= 1'b0;
      if (dm_ld || buf_ld) begin
        rsp_v_q    <= 1'b1;
        rsp_d_q    <= dm_ld ? mem_rsp_data : buf_rd_data;
        ld_cnt_q   <= ld_cnt_q + LW'(1);
        rsp_last_q <= (ld_cnt_q + LW'(1)) == cur_len_q;
      end

      // sequencing
      case (st_q)
        ST_IDLE, ST_PREFETCH: begin
          if (req_fire) begin
            cur_addr_q <= req_addr;
            cur_len_q  <= req_len;
            ld_cnt_q   <= '0;
            dm_cnt_q   <= '0;
            rsp_last_q <= 1'b0;
            st_q       <= pf_valid_q ? ST_HALT_CMP : ST_DEMAND;
          end else if ((st_q == ST_PREFETCH) && !busy_q && (pf_cnt_q == PW'(WIN))) begin
            st_q <= ST_IDLE;
          end
        end
        ST_HALT_CMP: begin
          if (match) begin
            st_q <= ST_RESUME;
          end else begin
            pf_valid_q <= 1'b0;
            pf_cnt_q   <= '0;
            st_q       <= ST_DEMAND;
          end
        end
        ST_DEMAND, ST_RESUME: begin
          if (txn_done) begin
            pf_base_q  <= cur_addr_q + AW'(WIN);
            pf_valid_q <= 1'b1;
            pf_cnt_q   <= '0;
            st_q       <= ST_PREFETCH;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid     = rsp_v_q;
  assign rsp_data      = rsp_d_q;
  assign mem_req_valid = mreq_v_q;
  assign mem_req_addr  = mreq_a_q;
endmodule

// File: rtl/wpf_prefetch_ctrl_chk.sv
module wpf_prefetch_ctrl_chk #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [DW-1:0] rsp_data,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_addr,
  input logic [CW-1:0] hit_count,
  input logic [CW-1:0] miss_count
);
  assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  assert_one_txn_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  assert_hit_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (hit_count == $past(hit_count)) || (hit_count == $past(hit_count) + CW'(1)));

  assert_miss_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (miss_count == $past(miss_count)) || (miss_count == $past(miss_count) + CW'(1)));

  assert_excl_evt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> !((hit_count != $past(hit_count)) && (miss_count != $past(miss_count))));
endmodule

bind wpf_prefetch_ctrl wpf_prefetch_ctrl_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (.*);

// File: tb/wpf_prefetch_ctrl_tb.sv
module wpf_prefetch_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16, DW = 16, WIN = 4, MAX_LEN = 8, CW = 8;
  localparam int LW = $clog2(MAX_LEN + 1);
  localparam int NVEC = 8;
  // gap[36:29] addr[28:13] len[12:9] hits[8:5] misses[4:1] no_mem_read[0]
  localparam logic [36:0] VEC [NVEC] = '{
    {8'd0,  16'h0100, 4'd4, 4'd0, 4'd0, 1'b0},  // R2 no prediction yet
    {8'd40, 16'h0104, 4'd4, 4'd1, 4'd0, 1'b1},  // R4 full window hit
    {8'd40, 16'h0200, 4'd2, 4'd1, 4'd1, 1'b0},  // R6 address mismatch
    {8'd2,  16'h0204, 4'd4, 4'd2, 4'd1, 1'b0},  // R5 resumed hit
    {8'd0,  16'h0208, 4'd6, 4'd2, 4'd2, 1'b0},  // R6 length over window
    {8'd0,  16'h020C, 4'd1, 4'd3, 4'd2, 1'b0},  // R5 single word hit
    {8'd5,  16'h0300, 4'd3, 4'd3, 4'd3, 1'b0},  // R6 mismatch mid-prefetch
    {8'd40, 16'h0304, 4'd3, 4'd4, 4'd3, 1'b1}   // R4 partial-length hit
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [DW-1:0] rsp_data;
  logic          mem_req_valid;
  logic          mem_req_ready;
  logic [AW-1:0] mem_req_addr;
  logic          mem_rsp_valid;
  logic [DW-1:0] mem_rsp_data;
  logic [CW-1:0] hit_count, miss_count;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int total_reqs = 0;
  logic [AW-1:0] req_log [16];
  logic p1_v = 1'b0, p2_v = 1'b0;
  logic [AW-1:0] p1_a = '0, p2_a = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wpf_prefetch_ctrl #(.AW(AW), .DW(DW), .WIN(WIN), .MAX_LEN(MAX_LEN), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .hit_count(hit_count), .miss_count(miss_count)
  );

  function automatic logic [DW-1:0] mdat(input logic [AW-1:0] a);
    return {a[7:0] ^ 8'h3C, a[15:8] + a[7:0]};
  endfunction

  // memory model: three-cycle round trip, stalls every fourth cycle
  assign mem_req_ready = (cyc % 4) != 3;
  assign mem_rsp_valid = p2_v;
  assign mem_rsp_data  = mdat(p2_a);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      p1_v <= 1'b0;
      p2_v <= 1'b0;
    end else begin
      p1_v <= mem_req_valid && mem_req_ready;
      p1_a <= mem_req_addr;
      p2_v <= p1_v;
      p2_a <= p1_a;
      if (mem_req_valid && mem_req_ready) begin
        req_log[total_reqs % 16] <= mem_req_addr;
        total_reqs <= total_reqs + 1;
      end
    end
  end

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got cycle %0d expected completion", cyc);
      report();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_txn(input logic [AW-1:0] a, input int n, input bit bp,
                         input int exp_hit, input int exp_miss, input bit no_rd,
                         input string tag);
    int got = 0;
    int k = 0;
    int snap;
    bit held = 1'b0;
    logic [DW-1:0] held_d = '0;
    @(negedge clk);
    snap = total_reqs;
    req_valid = 1'b1;
    req_addr  = a;
    req_len   = LW'(n);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R10", "req_ready after accept", longint'(req_ready), 0);
    while (got < n) begin
      if (held) begin
        chk(rsp_valid && rsp_data == held_d, "R8", "held word", longint'(rsp_data), longint'(held_d));
      end
      rsp_ready = bp ? ((k % 3) != 0) : 1'b1;
      held = rsp_valid && !rsp_ready;
      held_d = rsp_data;
      if (rsp_valid && rsp_ready) begin
        chk(rsp_data == mdat(a + AW'(got)), tag, "data word", longint'(rsp_data),
            longint'(mdat(a + AW'(got))));
        got++;
      end
      k++;
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    chk(rsp_valid == 1'b0, "R8", "no extra word", longint'(rsp_valid), 0);
    chk(hit_count == CW'(exp_hit), "R7", "hit_count", longint'(hit_count), longint'(exp_hit));
    chk(miss_count == CW'(exp_miss), "R7", "miss_count", longint'(miss_count), longint'(exp_miss));
    if (no_rd) chk(total_reqs == snap, "R4", "memory reads during hit", total_reqs - snap, 0);
  endtask

  task automatic chk_reset_state;
    chk(req_ready == 1'b1, "R1", "req_ready", longint'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid", longint'(rsp_valid), 0);
    chk(mem_req_valid == 1'b0, "R1", "mem_req_valid", longint'(mem_req_valid), 0);
    chk(hit_count == '0, "R1", "hit_count", longint'(hit_count), 0);
    chk(miss_count == '0, "R1", "miss_count", longint'(miss_count), 0);
  endtask

  initial begin
    int snap;
    repeat (3) @(negedge clk);
    chk_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    chk_reset_state();

    for (int i = 0; i < NVEC; i++) begin
      repeat (int'(VEC[i][36:29])) @(negedge clk);
      run_txn(VEC[i][28:13], int'(VEC[i][12:9]), 1'b0, int'(VEC[i][8:5]),
              int'(VEC[i][4:1]), VEC[i][0], (VEC[i][0] ? "R4" : "R2/R5/R6"));
    end

    // R3: the idle period fetches exactly the following window
    snap = total_reqs;
    repeat (60) @(negedge clk);
    chk(total_reqs - snap == WIN, "R3", "prefetch read count", total_reqs - snap, WIN);
    for (int j = 0; j < WIN; j++) begin
      chk(req_log[(snap + j) % 16] == AW'(16'h0308 + j), "R3", "prefetch address",
          longint'(req_log[(snap + j) % 16]), longint'(16'h0308 + j));
    end
    snap = total_reqs;
    repeat (30) @(negedge clk);
    chk(total_reqs == snap, "R3", "no reads after window", total_reqs - snap, 0);

    // R8: back-pressure on a full hit
    run_txn(16'h0308, 4, 1'b1, 5, 3, 1'b1, "R8");

    // R1 again after a reset in the middle of a run, then R7: no prediction counts nothing
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    chk_reset_state();
    run_txn(16'h030C, 2, 1'b0, 0, 0, 1'b0, "R7");

    report();
    $finish;
  end
endmodule